// File: doc/BRIEF.md
# Serial Engine Host Register and Interrupt Front End

This block is the register-mapped control face of an instruction-driven serial peripheral engine. A host issues single-cycle 32-bit reads and writes on a simple request bus. Through that bus it holds the engine in soft reset or releases it, arms and acknowledges interrupts, and reads the identifier left by the most recent synchronisation instruction. It also sees how much space remains in the command and transmit-data queues and how many words wait in the receive-data queue, pushes words into the two outbound queues, and pops or peeks the head of the receive queue.

The queue storage and the engine itself sit outside. The block sees each queue only through its fill level. It answers with one-cycle push and pop strobes that go out in the same cycle as the bus request. Four interrupt causes are collected into a pending vector. Three of them follow queue thresholds as live levels. The fourth is a sticky flag that a completed synchronisation instruction sets. A single level-sensitive interrupt line is raised whenever an enabled cause is pending.

Top module: `seng_host_regs`

## Requirements
- R1: After reset, engine_rst is 1, the enable mask, the sync flag and the stored sync identifier are 0, and irq is 0.
- R2: A write to offset 0x40 loads bit 0 of the write data into the soft-reset bit, which drives engine_rst and reads back at 0x40 in bit 0.
- R3: Offset 0x80 holds a 4-bit enable mask, written from write data bits [3:0]. It reads back with bits [31:4] as 0.
- R4: Offset 0x84 reads the pending vector. Bit 0 is cmd_level <= CMD_LOW. Bit 1 is sdo_level <= SDO_LOW. Bit 2 is sdi_level >= SDI_HIGH. Bit 3 is the sticky sync flag. Bits 0 to 2 follow the levels live, and writes do not change them.
- R5: A sync_valid pulse sets the sync flag and stores sync_id, which is readable at 0xC0. A write to 0x84 with bit 3 set clears the flag, and a write with bit 3 clear leaves it. If a sync arrives in the same cycle as a clear, the flag stays set.
- R6: Offset 0x88 reads the pending vector ANDed with the enable mask. irq is 1 exactly when that value is nonzero.
- R7: 0xD0 reads CMD_DEPTH minus cmd_level. 0xD4 reads SDO_DEPTH minus sdo_level. 0xD8 reads sdi_level.
- R8: A write to 0xE0 pulses cmd_push in the request cycle, with cmd_data equal to write data bits [15:0]. When cmd_level equals CMD_DEPTH there is no push.
- R9: A write to 0xE4 pulses sdo_push in the request cycle, with sdo_data equal to the full write word. When sdo_level equals SDO_DEPTH there is no push.
- R10: A read of 0xE8 pulses sdi_pop in the request cycle and returns sdi_head. When sdi_level is 0 there is no pop and the read returns 0.
- R11: A read of 0xEC returns sdi_head without any sdi_pop, and returns 0 when sdi_level is 0.
- R12: Read data and rd_valid appear in the cycle after the read request. Unmapped offsets read 0. Writes to read-only offsets have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Bus request strobe, one cycle per access |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | 8 | Byte offset |
| req_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after a read request |
| rd_data | output | 32 | Registered read data |
| irq | output | 1 | Level interrupt |
| engine_rst | output | 1 | Soft reset to the engine |
| cmd_push | output | 1 | Command queue push strobe |
| cmd_data | output | 16 | Command word |
| cmd_level | input | LVL_W | Command queue fill level |
| sdo_push | output | 1 | Transmit-data queue push strobe |
| sdo_data | output | 32 | Transmit-data word |
| sdo_level | input | LVL_W | Transmit-data queue fill level |
| sdi_pop | output | 1 | Receive-data queue pop strobe |
| sdi_head | input | 32 | Receive-data queue head word |
| sdi_level | input | LVL_W | Receive-data queue fill level |
| sync_valid | input | 1 | Engine reports a completed sync instruction |
| sync_id | input | ID_W | Identifier of that sync instruction |

## Verification
The levels are swept to either side of each threshold (CMD_LOW and CMD_LOW+1, SDI_HIGH-1 and SDI_HIGH). This separates an off-by-one in the comparison from a correct one, and separates a live level bit from a latched one. The sync flag is exercised with a set alone, a clear with bit 3 low, a clear with bit 3 high, and a set coinciding with a clear, which shows whether set or clear wins. The queue ports are tried full and not full, and empty and non-empty, with distinct head words. This tells a pop from a peek and tells a dropped access from one that passed. A cycle model compares irq, the strobes and the read path on every clock under all of these patterns.

// File: rtl/seng_pkg.sv
package seng_pkg;

  localparam logic [7:0] OFS_SOFT_RST  = 8'h40;
  localparam logic [7:0] OFS_IRQ_EN    = 8'h80;
  localparam logic [7:0] OFS_IRQ_PEND  = 8'h84;
  localparam logic [7:0] OFS_IRQ_SRC   = 8'h88;
  localparam logic [7:0] OFS_SYNC_ID   = 8'hC0;
  localparam logic [7:0] OFS_CMD_ROOM  = 8'hD0;
  localparam logic [7:0] OFS_SDO_ROOM  = 8'hD4;
  localparam logic [7:0] OFS_SDI_LVL   = 8'hD8;
  localparam logic [7:0] OFS_CMD_PUSH  = 8'hE0;
  localparam logic [7:0] OFS_SDO_PUSH  = 8'hE4;
  localparam logic [7:0] OFS_SDI_POP   = 8'hE8;
  localparam logic [7:0] OFS_SDI_PEEK  = 8'hEC;

  localparam int unsigned IRQ_W        = 4;
  localparam int unsigned BIT_CMD_LOW  = 0;
  localparam int unsigned BIT_SDO_LOW  = 1;
  localparam int unsigned BIT_SDI_HIGH = 2;
  localparam int unsigned BIT_SYNC     = 3;

  typedef struct packed {
    logic set_rst;
    logic set_en;
    logic clr_pend;
    logic push_cmd;
    logic push_sdo;
    logic pop_sdi;
    logic rd;
  } strobe_t;

  // free entries in a queue of the given depth
  function automatic logic [31:0] room_of(input logic [31:0] depth, input logic [31:0] level);
    return (level >= depth) ? 32'd0 : depth - level;
  endfunction

  function automatic logic at_or_below(input logic [31:0] level, input logic [31:0] thr);
    return level <= thr;
  endfunction

  function automatic logic at_or_above(input logic [31:0] level, input logic [31:0] thr);
    return level >= thr;
  endfunction

endpackage

// File: rtl/seng_decode.sv
module seng_decode
  import seng_pkg::*;
#(
  parameter int unsigned CMD_DEPTH = 16,
  parameter int unsigned SDO_DEPTH = 16,
  parameter int unsigned LVL_W     = 5
) (
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [7:0]       req_addr,
  input  logic [LVL_W-1:0] cmd_level,
  input  logic [LVL_W-1:0] sdo_level,
  input  logic [LVL_W-1:0] sdi_level,
  output strobe_t          strb
);

  logic wr_req, rd_req, cmd_full, sdo_full, sdi_empty;

  always_comb begin
    wr_req    = req_valid & req_write;
    rd_req    = req_valid & ~req_write;
    cmd_full  = 32'(cmd_level) >= CMD_DEPTH;
    sdo_full  = 32'(sdo_level) >= SDO_DEPTH;
    sdi_empty = (sdi_level == '0);

    strb.set_rst  = wr_req && (req_addr == OFS_SOFT_RST);
    strb.set_en   = wr_req && (req_addr == OFS_IRQ_EN);
    strb.clr_pend = wr_req && (req_addr == OFS_IRQ_PEND);
    strb.push_cmd = wr_req && (req_addr == OFS_CMD_PUSH) && !cmd_full;
    strb.push_sdo = wr_req && (req_addr == OFS_SDO_PUSH) && !sdo_full;
    strb.pop_sdi  = rd_req && (req_addr == OFS_SDI_POP)  && !sdi_empty;
    strb.rd       = rd_req;
  end

endmodule

// File: rtl/seng_irq_ctrl.sv
module seng_irq_ctrl
  import seng_pkg::*;
#(
  parameter int unsigned CMD_LOW  = 4,
  parameter int unsigned SDO_LOW  = 4,
  parameter int unsigned SDI_HIGH = 12,
  parameter int unsigned ID_W     = 8,
  parameter int unsigned LVL_W    = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_en,
  input  logic             clr_pend,
  input  logic [IRQ_W-1:0] wdata,
  input  logic             sync_valid,
  input  logic [ID_W-1:0]  sync_id,
  input  logic [LVL_W-1:0] cmd_level,
  input  logic [LVL_W-1:0] sdo_level,
  input  logic [LVL_W-1:0] sdi_level,
  output logic [IRQ_W-1:0] irq_en,
  output logic [IRQ_W-1:0] pend,
  output logic [IRQ_W-1:0] src,
  output logic [ID_W-1:0]  last_id,
  output logic             irq
);

  logic [IRQ_W-2:0] lvl_hit;
  logic             sync_flag;
  logic             sync_clr_req;

  always_comb begin
    lvl_hit[BIT_CMD_LOW]  = at_or_below(32'(cmd_level), CMD_LOW);
    lvl_hit[BIT_SDO_LOW]  = at_or_below(32'(sdo_level), SDO_LOW);
    lvl_hit[BIT_SDI_HIGH] = at_or_above(32'(sdi_level), SDI_HIGH);
    sync_clr_req          = clr_pend & wdata[BIT_SYNC];
    pend                  = {sync_flag, lvl_hit};
    src                   = pend & irq_en;
    irq                   = |src;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_en    <= '0;
      sync_flag <= 1'b0;
      last_id   <= '0;
    end else begin
      if (set_en) irq_en <= wdata;
      if (sync_valid) begin
        sync_flag <= 1'b1;
        last_id   <= sync_id;
      end else if (sync_clr_req) begin
        sync_flag <= 1'b0;
      end
    end
  end

  AST_SYNC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_flag && !sync_clr_req) |=> sync_flag); // R5
  AST_SYNC_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    sync_valid |=> (sync_flag && last_id == $past(sync_id))); // R5
  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en == '0) |-> !irq); // R6

endmodule

// File: rtl/seng_rd_mux.sv
module seng_rd_mux
  import seng_pkg::*;
#(
  parameter int unsigned CMD_DEPTH = 16,
  parameter int unsigned SDO_DEPTH = 16,
  parameter int unsigned ID_W      = 8,
  parameter int unsigned LVL_W     = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd,
  input  logic [7:0]       addr,
  input  logic             soft_rst,
  input  logic [IRQ_W-1:0] irq_en,
  input  logic [IRQ_W-1:0] pend,
  input  logic [IRQ_W-1:0] src,
  input  logic [ID_W-1:0]  last_id,
  input  logic [LVL_W-1:0] cmd_level,
  input  logic [LVL_W-1:0] sdo_level,
  input  logic [LVL_W-1:0] sdi_level,
  input  logic [31:0]      sdi_head,
  output logic             rd_valid,
  output logic [31:0]      rd_data
);

  logic [31:0] head_or_zero;
  logic [31:0] sel;

  always_comb begin
    head_or_zero = (sdi_level == '0) ? 32'd0 : sdi_head;
    case (addr)
      OFS_SOFT_RST: sel = {31'd0, soft_rst};
      OFS_IRQ_EN:   sel = 32'(irq_en);
      OFS_IRQ_PEND: sel = 32'(pend);
      OFS_IRQ_SRC:  sel = 32'(src);
      OFS_SYNC_ID:  sel = 32'(last_id);
      OFS_CMD_ROOM: sel = room_of(CMD_DEPTH, 32'(cmd_level));
      OFS_SDO_ROOM: sel = room_of(SDO_DEPTH, 32'(sdo_level));
      OFS_SDI_LVL:  sel = 32'(sdi_level);
      OFS_SDI_POP,
      OFS_SDI_PEEK: sel = head_or_zero;
      default:      sel = 32'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd;
      if (rd) rd_data <= sel;
    end
  end

  AST_RD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    rd |=> rd_valid); // R12
  AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && (addr == OFS_SDI_POP || addr == OFS_SDI_PEEK) && sdi_level == '0) |=> (rd_data == 32'd0)); // R10

endmodule

// File: rtl/seng_host_regs.sv
module seng_host_regs
  import seng_pkg::*;
#(
  parameter int unsigned CMD_DEPTH = 16,
  parameter int unsigned SDO_DEPTH = 16,
  parameter int unsigned SDI_DEPTH = 16,
  parameter int unsigned CMD_LOW   = 4,
  parameter int unsigned SDO_LOW   = 4,
  parameter int unsigned SDI_HIGH  = 12,
  parameter int unsigned ID_W      = 8,
  localparam int unsigned MAX_DEPTH = (CMD_DEPTH > SDO_DEPTH)
                                      ? ((CMD_DEPTH > SDI_DEPTH) ? CMD_DEPTH : SDI_DEPTH)
                                      : ((SDO_DEPTH > SDI_DEPTH) ? SDO_DEPTH : SDI_DEPTH),
  localparam int unsigned LVL_W = $clog2(MAX_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [7:0]       req_addr,
  input  logic [31:0]      req_wdata,
  output logic             rd_valid,
  output logic [31:0]      rd_data,
  output logic             irq,
  output logic             engine_rst,
  output logic             cmd_push,
  output logic [15:0]      cmd_data,
  input  logic [LVL_W-1:0] cmd_level,
  output logic             sdo_push,
  output logic [31:0]      sdo_data,
  input  logic [LVL_W-1:0] sdo_level,
  output logic             sdi_pop,
  input  logic [31:0]      sdi_head,
  input  logic [LVL_W-1:0] sdi_level,
  input  logic             sync_valid,
  input  logic [ID_W-1:0]  sync_id
);

  strobe_t          strb;
  logic [IRQ_W-1:0] irq_en, pend, src;
  logic [ID_W-1:0]  last_id;
  logic             soft_rst;

  seng_decode #(
    .CMD_DEPTH(CMD_DEPTH), .SDO_DEPTH(SDO_DEPTH), .LVL_W(LVL_W)
  ) u_decode (
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .cmd_level(cmd_level), .sdo_level(sdo_level), .sdi_level(sdi_level),
    .strb(strb)
  );

  seng_irq_ctrl #(
    .CMD_LOW(CMD_LOW), .SDO_LOW(SDO_LOW), .SDI_HIGH(SDI_HIGH),
    .ID_W(ID_W), .LVL_W(LVL_W)
  ) u_irq (
    .clk(clk), .rst_n(rst_n),
    .set_en(strb.set_en), .clr_pend(strb.clr_pend), .wdata(req_wdata[IRQ_W-1:0]),
    .sync_valid(sync_valid), .sync_id(sync_id),
    .cmd_level(cmd_level), .sdo_level(sdo_level), .sdi_level(sdi_level),
    .irq_en(irq_en), .pend(pend), .src(src), .last_id(last_id), .irq(irq)
  );

  seng_rd_mux #(
    .CMD_DEPTH(CMD_DEPTH), .SDO_DEPTH(SDO_DEPTH), .ID_W(ID_W), .LVL_W(LVL_W)
  ) u_rd (
    .clk(clk), .rst_n(rst_n), .rd(strb.rd), .addr(req_addr),
    .soft_rst(soft_rst), .irq_en(irq_en), .pend(pend), .src(src), .last_id(last_id),
    .cmd_level(cmd_level), .sdo_level(sdo_level), .sdi_level(sdi_level),
    .sdi_head(sdi_head), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)            soft_rst <= 1'b1;
    else if (strb.set_rst) soft_rst <= req_wdata[0];
  end

  always_comb begin
    engine_rst = soft_rst;
    cmd_push   = strb.push_cmd;
    cmd_data   = req_wdata[15:0];
    sdo_push   = strb.push_sdo;
    sdo_data   = req_wdata;
    sdi_pop    = strb.pop_sdi;
  end

  AST_NO_CMD_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(cmd_level) >= CMD_DEPTH) |-> !cmd_push); // R8
  AST_NO_SDO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(sdo_level) >= SDO_DEPTH) |-> !sdo_push); // R9
  AST_NO_SDI_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (sdi_level == '0) |-> !sdi_pop); // R10
  AST_PEEK_NO_POP: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && req_addr == OFS_SDI_PEEK) |-> !sdi_pop); // R11
  AST_SOFT_RST_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_addr == OFS_SOFT_RST) |=> (engine_rst == $past(req_wdata[0]))); // R2

endmodule

// File: tb/sim_seng_host_regs.sv
module sim_seng_host_regs;

  localparam int DEP = 16;
  localparam int LOW_C = 4;
  localparam int LOW_O = 4;
  localparam int HIGH_I = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [7:0]  req_addr = 8'h00;
  logic [31:0] req_wdata = 32'd0;
  logic [4:0]  cmd_level = 5'd10, sdo_level = 5'd10, sdi_level = 5'd0;
  logic [31:0] sdi_head = 32'd0;
  logic        sync_valid = 1'b0;
  logic [7:0]  sync_id = 8'd0;

  logic        rd_valid, irq, engine_rst, cmd_push, sdo_push, sdi_pop;
  logic [31:0] rd_data, sdo_data;
  logic [15:0] cmd_data;

  seng_host_regs u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
    .irq(irq), .engine_rst(engine_rst), .cmd_push(cmd_push), .cmd_data(cmd_data),
    .cmd_level(cmd_level), .sdo_push(sdo_push), .sdo_data(sdo_data), .sdo_level(sdo_level),
    .sdi_pop(sdi_pop), .sdi_head(sdi_head), .sdi_level(sdi_level),
    .sync_valid(sync_valid), .sync_id(sync_id)
  );

  int total = 0;
  int bad = 0;
  bit done = 0;

  // reference model state
  bit          m_rst = 1;
  logic [3:0]  m_en = 4'd0;
  bit          m_sync = 0;
  logic [7:0]  m_id = 8'd0;
  bit          m_rdv = 0;
  logic [31:0] m_rdata = 32'd0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] m_pend();
    logic [3:0] p;
    p[0] = int'(cmd_level) <= LOW_C;
    p[1] = int'(sdo_level) <= LOW_O;
    p[2] = int'(sdi_level) >= HIGH_I;
    p[3] = m_sync;
    return p;
  endfunction

  function automatic logic [31:0] m_read(input logic [7:0] a);
    int v;
    case (a)
      8'h40: v = int'(m_rst);
      8'h80: v = int'(m_en);
      8'h84: v = int'(m_pend());
      8'h88: v = int'(m_pend() & m_en);
      8'hC0: v = int'(m_id);
      8'hD0: v = DEP - int'(cmd_level);
      8'hD4: v = DEP - int'(sdo_level);
      8'hD8: v = int'(sdi_level);
      8'hE8, 8'hEC: v = (sdi_level == 0) ? 0 : int'(sdi_head);
      default: v = 0;
    endcase
    return 32'(v);
  endfunction

  // cycle model compared on every clock
  initial begin
    forever begin
      @(negedge clk);
      #8;
      if (!rst_n) begin
        m_rst = 1; m_en = 0; m_sync = 0; m_id = 0; m_rdv = 0; m_rdata = 0;
      end else begin
        bit rd_e, wr_e, cp, sp, pp;
        logic [31:0] nxt;
        rd_e = req_valid && !req_write;
        wr_e = req_valid && req_write;
        cp = wr_e && req_addr == 8'hE0 && int'(cmd_level) < DEP;
        sp = wr_e && req_addr == 8'hE4 && int'(sdo_level) < DEP;
        pp = rd_e && req_addr == 8'hE8 && sdi_level != 0;
        chk("R6 irq", 32'(irq), 32'(|(m_pend() & m_en)));
        chk("R2 engine_rst", 32'(engine_rst), 32'(m_rst));
        chk("R8 cmd_push", 32'(cmd_push), 32'(cp));
        if (cp) chk("R8 cmd_data", 32'(cmd_data), {16'd0, req_wdata[15:0]});
        chk("R9 sdo_push", 32'(sdo_push), 32'(sp));
        if (sp) chk("R9 sdo_data", sdo_data, req_wdata);
        chk("R10 sdi_pop", 32'(sdi_pop), 32'(pp));
        chk("R12 rd_valid", 32'(rd_valid), 32'(m_rdv));
        if (m_rdv) chk("R12 rd_data", rd_data, m_rdata);
        nxt = m_read(req_addr);
        m_rdv = rd_e;
        if (rd_e) m_rdata = nxt;
        if (wr_e && req_addr == 8'h40) m_rst = req_wdata[0];
        if (wr_e && req_addr == 8'h80) m_en = req_wdata[3:0];
        if (sync_valid) begin
          m_sync = 1; m_id = sync_id;
        end else if (wr_e && req_addr == 8'h84 && req_wdata[3]) begin
          m_sync = 0;
        end
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); #1;
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
    @(negedge clk); #1;
    req_valid = 0; req_write = 0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    @(negedge clk); #1;
    req_valid = 1; req_write = 0; req_addr = a;
    @(negedge clk); #1;
    req_valid = 0;
    #2;
    chk(tag, rd_data, e);
    chk(tag, 32'(rd_valid), 32'd1);
  endtask

  task automatic pulse_sync(input logic [7:0] id);
    @(negedge clk); #1;
    sync_valid = 1; sync_id = id;
    @(negedge clk); #1;
    sync_valid = 0;
  endtask

  task automatic push_try(input logic [7:0] a, input logic [31:0] d, input bit exp, input string tag);
    @(negedge clk); #1;
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
    #5;
    if (a == 8'hE0) begin
      chk(tag, 32'(cmd_push), 32'(exp));
      if (exp) chk(tag, 32'(cmd_data), {16'd0, d[15:0]});
    end else begin
      chk(tag, 32'(sdo_push), 32'(exp));
      if (exp) chk(tag, sdo_data, d);
    end
    @(negedge clk); #1;
    req_valid = 0; req_write = 0;
  endtask

  task automatic pop_try(input logic [7:0] a, input bit exp_pop, input logic [31:0] e, input string tag);
    @(negedge clk); #1;
    req_valid = 1; req_write = 0; req_addr = a;
    #5;
    chk(tag, 32'(sdi_pop), 32'(exp_pop));
    @(negedge clk); #1;
    req_valid = 0;
    #2;
    chk(tag, rd_data, e);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL R12 watchdog expired act=0 exp=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    #1 rst_n = 1;
    // R1 reset state
    chk("R1 irq", 32'(irq), 32'd0);
    chk("R1 engine_rst", 32'(engine_rst), 32'd1);
    rd(8'h40, 32'd1, "R1 soft reset bit");
    rd(8'h80, 32'd0, "R1 enable");
    rd(8'h84, 32'd0, "R1 pending");
    rd(8'hC0, 32'd0, "R1 sync id");
    // R2 soft reset
    wr(8'h40, 32'd0);
    rd(8'h40, 32'd0, "R2 release");
    chk("R2 engine_rst low", 32'(engine_rst), 32'd0);
    wr(8'h40, 32'd3);
    rd(8'h40, 32'd1, "R2 hold");
    wr(8'h40, 32'd0);
    // R3 enable mask
    wr(8'h80, 32'hFFFF_FFF0);
    rd(8'h80, 32'd0, "R3 upper bits");
    wr(8'h80, 32'hFFFF_FFFF);
    rd(8'h80, 32'h0000_000F, "R3 mask");
    wr(8'h80, 32'd0);
    // R4 level bits
    cmd_level = 5'd4;  rd(8'h84, 32'h1, "R4 cmd at low");
    cmd_level = 5'd5;  rd(8'h84, 32'h0, "R4 cmd above low");
    sdo_level = 5'd4;  rd(8'h84, 32'h2, "R4 sdo at low");
    sdo_level = 5'd5;  rd(8'h84, 32'h0, "R4 sdo above low");
    sdi_level = 5'd12; rd(8'h84, 32'h4, "R4 sdi at high");
    wr(8'h84, 32'h7);  rd(8'h84, 32'h4, "R4 write ignored");
    sdi_level = 5'd11; rd(8'h84, 32'h0, "R4 sdi below high");
    sdi_level = 5'd0; cmd_level = 5'd10; sdo_level = 5'd10;
    // R5 sync flag
    pulse_sync(8'h5A);
    rd(8'h84, 32'h8, "R5 sync set");
    rd(8'hC0, 32'h5A, "R5 sync id");
    wr(8'h84, 32'h7);  rd(8'h84, 32'h8, "R5 clear without bit3");
    wr(8'h84, 32'h8);  rd(8'h84, 32'h0, "R5 clear");
    @(negedge clk); #1;
    sync_valid = 1; sync_id = 8'h33;
    req_valid = 1; req_write = 1; req_addr = 8'h84; req_wdata = 32'hFF;
    @(negedge clk); #1;
    sync_valid = 0; req_valid = 0; req_write = 0;
    rd(8'h84, 32'h8, "R5 set beats clear");
    rd(8'hC0, 32'h33, "R5 id updated");
    wr(8'h84, 32'hFF); rd(8'h84, 32'h0, "R5 clear all");
    // R6 masked source and irq
    wr(8'h80, 32'h2);
    cmd_level = 5'd3; sdo_level = 5'd3;
    rd(8'h88, 32'h2, "R6 source masked");
    chk("R6 irq high", 32'(irq), 32'd1);
    wr(8'h80, 32'h0);
    rd(8'h88, 32'h0, "R6 source none");
    chk("R6 irq low", 32'(irq), 32'd0);
    wr(8'h80, 32'h8); pulse_sync(8'h01);
    chk("R6 irq from sync", 32'(irq), 32'd1);
    wr(8'h84, 32'h8);
    chk("R6 irq cleared", 32'(irq), 32'd0);
    wr(8'h80, 32'h0);
    // R7 room and level
    rd(8'hD0, 32'd13, "R7 cmd room");
    sdo_level = 5'd16; rd(8'hD4, 32'd0, "R7 sdo room full");
    sdo_level = 5'd1;  rd(8'hD4, 32'd15, "R7 sdo room");
    sdi_level = 5'd7;  rd(8'hD8, 32'd7, "R7 sdi level");
    // R8 command push
    push_try(8'hE0, 32'hABCD_1234, 1'b1, "R8 push");
    cmd_level = 5'd16;
    push_try(8'hE0, 32'h0000_5555, 1'b0, "R8 full drop");
    rd(8'hD0, 32'd0, "R8 room full");
    cmd_level = 5'd10;
    // R9 sdo push
    sdo_level = 5'd16;
    push_try(8'hE4, 32'h1111_2222, 1'b0, "R9 full drop");
    sdo_level = 5'd15;
    push_try(8'hE4, 32'hDEAD_BEEF, 1'b1, "R9 push");
    sdo_level = 5'd10;
    // R10 pop
    sdi_level = 5'd3; sdi_head = 32'hCAFE_0001;
    pop_try(8'hE8, 1'b1, 32'hCAFE_0001, "R10 pop");
    sdi_level = 5'd0; sdi_head = 32'h7777_7777;
    pop_try(8'hE8, 1'b0, 32'd0, "R10 empty pop");
    // R11 peek
    sdi_level = 5'd2; sdi_head = 32'h1234_5678;
    pop_try(8'hEC, 1'b0, 32'h1234_5678, "R11 peek");
    sdi_level = 5'd0;
    pop_try(8'hEC, 1'b0, 32'd0, "R11 empty peek");
    // R12 unmapped and read-only
    rd(8'h44, 32'd0, "R12 unmapped");
    sdi_level = 5'd5;
    wr(8'hD8, 32'hFFFF);
    rd(8'hD8, 32'd5, "R12 read-only write");
    wr(8'hC0, 32'h99);
    rd(8'hC0, 32'h01, "R12 id read-only");
    repeat (3) @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule